// File: doc/BRIEF.md
# Triggered Continuous Pulse Train Generator

The block turns a stream of single-cycle source enables into a continuous rectangular pulse train. Each source enable counts as one source period. The output holds low for a programmed number of source periods, then high for another programmed number, and repeats. The output rate is therefore the source rate divided by the sum of the two widths. Software-side logic programs the two widths and a gate mode, then raises the arm input. The generator runs until arm is dropped.

The gate input has two uses, picked by the mode input when the block is armed. In start-trigger mode the generator waits after arming and begins on the first rising edge of the gate; it ignores the gate after that until it is re-armed. In pause mode the generator begins as soon as it is armed. While the gate is high, it freezes both its count and its output level, and it resumes from the frozen point when the gate falls. A running flag shows when the generator is producing the train.

Top module: `pulse_train_gen`

## Requirements
- R1: While rst_ni is low, and after reset until arming, pulse_o and running_o are 0.
- R2: With start_mode_i = 0, arm_i seen high at a clock edge while idle makes running_o 1 after that edge, with pulse_o low and a fresh count.
- R3: While running and not paused, pulse_o stays low for N source enables, where N = low_cnt_i captured at arming. It then stays high for M enables, where M = high_cnt_i captured at arming. The phase changes at the clock edge that samples the last enable of the phase, so the period is M+N enables.
- R4: With start_mode_i = 1, the armed generator keeps running_o and pulse_o at 0 until a rising edge of gate_i is sampled, meaning gate_i is 1 at an edge after being 0 at the previous edge. running_o is 1 after that edge. An edge that coincides with the arming edge is not taken.
- R5: In start-trigger mode, gate_i has no effect once running: neither later edges nor a high level pause or restart the train.
- R6: In pause mode, a source enable sampled at an edge where gate_i is 1 is not counted, and pulse_o keeps its level. Counting resumes from the frozen count when gate_i is 0.
- R7: high_cnt_i, low_cnt_i and start_mode_i are sampled only when arming; changes while armed have no effect.
- R8: A width of 0 is treated as 1.
- R9: arm_i sampled low drives pulse_o and running_o to 0 after that edge. Re-arming restarts from the start of the low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_en_i | input | 1 | Single-cycle source enable; one per source period |
| arm_i | input | 1 | Level; high keeps the generator armed |
| gate_i | input | 1 | Start trigger (rising edge) or pause (high level) |
| start_mode_i | input | 1 | 1 = gate is a start trigger, 0 = gate is a pause |
| high_cnt_i | input | 32 | High phase width M in source periods |
| low_cnt_i | input | 32 | Low phase width N in source periods |
| pulse_o | output | 1 | Pulse train output |
| running_o | output | 1 | High while generating |

## Verification
In pause mode, a source enable and a gate-high pause can fall on the same clock edge, and the pause must win so the enable is lost rather than counted. The bench provokes this by driving pseudo-random enables and a pseudo-random gate pattern together, so coincident edges occur at every count position, including the last count of a phase. A behavioural model that counts remaining periods predicts pulse_o and running_o, and the two are compared every cycle. A second coincidence, the start-trigger edge landing with an enable, is judged the same way: the enable at the trigger edge is not counted.

// File: rtl/pulse_train_pkg.sv
package pulse_train_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } pt_state_e;
endpackage

// File: rtl/pt_gate_edge.sv
module pt_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic rise_o
);
  logic gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_i;
  end

  assign rise_o = gate_i & ~gate_q;
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pulse_train_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             gate_i,
  input  logic             rise_i,
  input  logic             src_en_i,
  input  logic             start_mode_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  output logic [CNT_W-1:0] m_o,
  output logic [CNT_W-1:0] n_o,
  output logic             run_o,
  output logic             adv_o,
  output logic             running_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  pt_state_e        state_q, state_d;
  logic [CNT_W-1:0] m_q, n_q;
  logic             trig_mode_q;
  logic             capture;

  assign capture = (state_q == ST_IDLE) && arm_i;

  always_comb begin
    state_d = state_q;
    if (!arm_i) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_d = start_mode_i ? ST_WAIT : ST_RUN;
        ST_WAIT: if (rise_i) state_d = ST_RUN;
        default: state_d = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      m_q         <= ONE;
      n_q         <= ONE;
      trig_mode_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (capture) begin
        m_q         <= (high_cnt_i == '0) ? ONE : high_cnt_i;  // R8 clamp
        n_q         <= (low_cnt_i == '0) ? ONE : low_cnt_i;
        trig_mode_q <= start_mode_i;
      end
    end
  end

  assign run_o     = (state_q == ST_RUN) && arm_i;
  assign adv_o     = run_o && src_en_i && !(!trig_mode_q && gate_i);
  assign running_o = (state_q == ST_RUN);
  assign m_o       = m_q;
  assign n_o       = n_q;

  p_width_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> (state_q == ST_IDLE) || ($stable(m_q) && $stable(n_q) && $stable(trig_mode_q)));

  p_wait_needs_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && arm_i && !rise_i) |=> (state_q == ST_WAIT));

  p_width_nonzero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_q != '0) && (n_q != '0));

  p_disarm_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pt_phase.sv
module pt_phase #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             adv_i,
  input  logic [CNT_W-1:0] m_i,
  input  logic [CNT_W-1:0] n_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             high_q;
  logic [CNT_W-1:0] limit;
  logic             last;

  assign limit = high_q ? m_i : n_i;
  assign last  = (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q  <= '0;
      high_q <= 1'b0;
    end else if (adv_i) begin
      if (last) begin
        cnt_q  <= '0;
        high_q <= ~high_q;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign pulse_o = high_q;

  p_hold_on_pause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !adv_i) |=> !run_i || ($stable(high_q) && $stable(cnt_q)));

  p_idle_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !high_q && (cnt_q == '0));

  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit);
endmodule

// File: rtl/pulse_train_gen.sv
module pulse_train_gen #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_en_i,
  input  logic             arm_i,
  input  logic             gate_i,
  input  logic             start_mode_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  output logic             pulse_o,
  output logic             running_o
);
  logic             rise;
  logic             run;
  logic             adv;
  logic [CNT_W-1:0] m_w, n_w;

  pt_gate_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .gate_i (gate_i),
    .rise_o (rise)
  );

  pt_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .arm_i        (arm_i),
    .gate_i       (gate_i),
    .rise_i       (rise),
    .src_en_i     (src_en_i),
    .start_mode_i (start_mode_i),
    .high_cnt_i   (high_cnt_i),
    .low_cnt_i    (low_cnt_i),
    .m_o          (m_w),
    .n_o          (n_w),
    .run_o        (run),
    .adv_o        (adv),
    .running_o    (running_o)
  );

  pt_phase #(.CNT_W(CNT_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .adv_i   (adv),
    .m_i     (m_w),
    .n_i     (n_w),
    .pulse_o (pulse_o)
  );

  p_reset_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !pulse_o);

  p_start_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> !pulse_o);
endmodule

// File: tb/pulse_train_gen_test.sv
module pulse_train_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_en = 1'b0, arm = 1'b0, gate = 1'b0, start_mode = 1'b0;
  logic [31:0] high_cnt = 32'd1, low_cnt = 32'd1;
  logic        pulse, running;

  always #4 clk = ~clk;

  pulse_train_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .src_en_i(src_en), .arm_i(arm), .gate_i(gate),
    .start_mode_i(start_mode), .high_cnt_i(high_cnt), .low_cnt_i(low_cnt),
    .pulse_o(pulse), .running_o(running)
  );

  int    tests = 0, fails = 0;
  string cur_req = "R1";
  bit    done = 0;

  // behavioural model: phase = remaining periods
  int st_m = 0, rem_m = 0, m_m = 1, n_m = 1;
  bit trig_m = 0, out_m = 0, gprev_m = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_m = 0; out_m = 0; rem_m = 0; gprev_m = 0;
    end else begin
      if (!arm) begin
        st_m = 0; out_m = 0;
      end else if (st_m == 0) begin
        m_m = (high_cnt == 0) ? 1 : int'(high_cnt);
        n_m = (low_cnt == 0) ? 1 : int'(low_cnt);
        trig_m = start_mode;
        out_m = 0; rem_m = n_m;
        st_m = start_mode ? 1 : 2;
      end else if (st_m == 1) begin
        if (gate && !gprev_m) begin st_m = 2; rem_m = n_m; out_m = 0; end
      end else if (src_en && !(!trig_m && gate)) begin
        rem_m = rem_m - 1;
        if (rem_m == 0) begin
          out_m = !out_m;
          rem_m = out_m ? m_m : n_m;
        end
      end
      gprev_m = gate;
    end
  end

  task automatic chk(string r, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " pulse_o"}, int'(pulse), int'(out_m));
      chk({cur_req, " running_o"}, int'(running), (st_m == 2) ? 1 : 0);
    end
  end

  // source enable patterns
  int       tick_mode = 0;
  int       cyc = 0;
  bit [15:0] lfsr = 16'hACE1;
  bit       rnd_gate = 0;
  always @(negedge clk) begin
    #1;
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (tick_mode)
      0: src_en = 1'b1;
      1: src_en = (cyc % 3 == 0);
      default: src_en = lfsr[0];
    endcase
    if (rnd_gate) gate = lfsr[3] & lfsr[7];
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_at_gap();
    @(negedge clk); #2;
  endtask

  task automatic wait_lvl(logic lvl);
    int g = 0;
    while (pulse !== lvl && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic count_lvl(logic lvl, output int n);
    n = 0;
    while (pulse === lvl && n < 2000) begin @(negedge clk); n++; end
  endtask

  initial begin
    int hi, lo;
    logic held;
    step(3);
    chk("R1 pulse_o in reset", int'(pulse), 0);
    chk("R1 running_o in reset", int'(running), 0);
    drive_at_gap(); rst_n = 1'b1;
    step(2);
    chk("R1 idle after reset", int'(running), 0);

    // free-running start
    cur_req = "R2";
    tick_mode = 0;
    drive_at_gap(); high_cnt = 3; low_cnt = 5; start_mode = 0; arm = 1;
    step(1);
    chk("R2 running after arm", int'(running), 1);
    chk("R2 starts low", int'(pulse), 0);

    cur_req = "R3";
    wait_lvl(0); wait_lvl(1);
    count_lvl(1, hi); count_lvl(0, lo);
    chk("R3 high width", hi, 3);
    chk("R3 low width", lo, 5);
    tick_mode = 1; step(60); tick_mode = 0;

    // widths changed while armed
    cur_req = "R7";
    drive_at_gap(); high_cnt = 9; low_cnt = 2; start_mode = 1;
    wait_lvl(0); wait_lvl(1);
    count_lvl(1, hi); count_lvl(0, lo);
    chk("R7 high width unchanged", hi, 3);
    chk("R7 low width unchanged", lo, 5);

    cur_req = "R9";
    drive_at_gap(); arm = 0;
    step(1);
    chk("R9 pulse low after disarm", int'(pulse), 0);
    chk("R9 running low after disarm", int'(running), 0);

    // zero widths
    cur_req = "R8";
    drive_at_gap(); high_cnt = 0; low_cnt = 0; start_mode = 0; arm = 1;
    wait_lvl(0); wait_lvl(1);
    count_lvl(1, hi); count_lvl(0, lo);
    chk("R8 zero high width", hi, 1);
    chk("R8 zero low width", lo, 1);
    drive_at_gap(); arm = 0;

    // pause mode with coincident enables and gate
    cur_req = "R6";
    drive_at_gap(); high_cnt = 4; low_cnt = 3; start_mode = 0; arm = 1;
    tick_mode = 2; rnd_gate = 1;
    step(400);
    rnd_gate = 0; tick_mode = 0;
    drive_at_gap(); gate = 0;
    step(5);
    drive_at_gap(); gate = 1;
    step(1); held = pulse;
    step(12);
    chk("R6 level frozen during pause", int'(pulse), int'(held));
    drive_at_gap(); gate = 0;
    step(20);
    drive_at_gap(); arm = 0;
    step(2);

    // start trigger mode
    cur_req = "R4";
    drive_at_gap(); high_cnt = 4; low_cnt = 4; start_mode = 1; gate = 0; arm = 1;
    step(10);
    chk("R4 waiting for trigger running_o", int'(running), 0);
    chk("R4 waiting for trigger pulse_o", int'(pulse), 0);
    drive_at_gap(); gate = 1;
    step(1);
    chk("R4 running after gate edge", int'(running), 1);

    cur_req = "R5";
    wait_lvl(0); wait_lvl(1);
    count_lvl(1, hi); count_lvl(0, lo);
    chk("R5 high width with gate held", hi, 4);
    chk("R5 low width with gate held", lo, 4);
    tick_mode = 2; rnd_gate = 1;
    step(200);
    rnd_gate = 0; tick_mode = 0;
    chk("R5 still running after gate activity", int'(running), 1);
    drive_at_gap(); arm = 0; gate = 0;
    step(2);

    // re-arm restarts from low phase
    cur_req = "R9";
    drive_at_gap(); high_cnt = 2; low_cnt = 6; start_mode = 0; arm = 1;
    step(1);
    count_lvl(0, lo);
    chk("R9 first low phase after re-arm", lo, 6);
    step(10);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule